// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This block sits in the execute stage of a five-stage pipeline. For each of the two ALU inputs it chooses where the operand comes from. There are three sources: the value read from the register file, the result held in the execute/memory pipeline register, or the value held in the memory/writeback pipeline register. It is purely combinational. Its two select outputs drive the operand multiplexers in front of the ALU in the same cycle.

The unit receives the two source register numbers of the instruction now in execute. It also receives two flags from decode that say whether the instruction really reads each source. Register-register and branch instructions read both sources. Loads, stores and immediate forms read only the first. From each of the two later stages it receives the destination register number and the register-write enable.

A stage is a valid producer only when its write enable is set and its destination is not register zero. When both later stages produce the same register, the execute/memory result is newer and wins.

Top module: `fwd_unit`

## Requirements
- R1: When the first-operand use flag is low, the first select is 00 (register file), whatever the pipeline stages hold.
- R2: For an operand that is used, the select is 10 when the execute/memory stage has its write enable set, its destination non-zero and its destination equal to that operand's register.
- R3: For an operand that is used, the select is 01 when the memory/writeback stage has its write enable set, its destination non-zero and equal to that operand's register, and R2 does not apply to that operand.
- R4: When both stages qualify for the same operand, the select is 10 (the newer execute/memory result has priority).
- R5: A stage whose destination is register 0 never causes forwarding; with no other qualifying stage the select stays 00.
- R6: A stage whose write enable is low never causes forwarding, even when its destination matches the operand's register.
- R7: The two operands resolve independently in the same cycle. For example, the first select can be 10 while the second is 01.
- R8: When the second-operand use flag is low (load, store or immediate instruction), the second select is 00 regardless of any match.
- R9: The value 11 never appears on either select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exRs | input | REG_BITS | First source register of the instruction in execute |
| exRt | input | REG_BITS | Second source register of the instruction in execute |
| useRs | input | 1 | Instruction reads the first source |
| useRt | input | 1 | Instruction reads the second source |
| exMemDst | input | REG_BITS | Destination register held in execute/memory |
| exMemWe | input | 1 | Register-write enable held in execute/memory |
| memWbDst | input | REG_BITS | Destination register held in memory/writeback |
| memWbWe | input | 1 | Register-write enable held in memory/writeback |
| selA | output | 2 | First ALU operand select: 00 register file, 10 execute/memory, 01 memory/writeback |
| selB | output | 2 | Second ALU operand select, same encoding |

## Verification
The block holds no state, so a wrong match or a wrong priority decision shows on the select outputs in the same cycle as the input pattern that exposes it. Typical faults are a swapped priority, a missing register-zero or enable qualifier, or a use flag that is ignored. Each of these gives a wrong select code for a specific set of register numbers. A full sweep over a narrow register field therefore exposes every such fault. The bench also checks the two operands against each other, so that a cross-wired or shared comparison is caught.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMWB   = 2'b01,
    SRC_EXMEM   = 2'b10
  } opSrc_e;

  typedef struct packed {
    logic exHit;
    logic wbHit;
  } hitStrobe_t;
endpackage

// File: rtl/fwd_match_ctrl.sv
module fwd_match_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_BITS = 5,
  parameter int NUM_OPS = 2
) (
  input  logic [NUM_OPS-1:0][REG_BITS-1:0] srcReg,
  input  logic [NUM_OPS-1:0]               srcUsed,
  input  logic [REG_BITS-1:0]              exMemDst,
  input  logic                             exMemWe,
  input  logic [REG_BITS-1:0]              memWbDst,
  input  logic                             memWbWe,
  output hitStrobe_t [NUM_OPS-1:0]         strobe
);
  localparam logic [REG_BITS-1:0] ZERO_REG = '0;

  logic exLive;
  logic wbLive;

  assign exLive = exMemWe && (exMemDst != ZERO_REG);
  assign wbLive = memWbWe && (memWbDst != ZERO_REG);

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    always_comb begin
      strobe[op].exHit = srcUsed[op] && exLive && (exMemDst == srcReg[op]);
      strobe[op].wbHit = srcUsed[op] && wbLive && (memWbDst == srcReg[op]);
    end
  end
endmodule

// File: rtl/fwd_sel_path.sv
module fwd_sel_path
  import fwd_pkg::*;
#(
  parameter int NUM_OPS = 2
) (
  input  hitStrobe_t [NUM_OPS-1:0] strobe,
  output logic [NUM_OPS-1:0][1:0]  sel
);
  for (genvar op = 0; op < NUM_OPS; op++) begin : g_mux
    always_comb begin
      if (strobe[op].exHit)      sel[op] = SRC_EXMEM;
      else if (strobe[op].wbHit) sel[op] = SRC_MEMWB;
      else                       sel[op] = SRC_REGFILE;
    end
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_BITS = 5
) (
  input  logic [REG_BITS-1:0] exRs,
  input  logic [REG_BITS-1:0] exRt,
  input  logic                useRs,
  input  logic                useRt,
  input  logic [REG_BITS-1:0] exMemDst,
  input  logic                exMemWe,
  input  logic [REG_BITS-1:0] memWbDst,
  input  logic                memWbWe,
  output logic [1:0]          selA,
  output logic [1:0]          selB
);
  localparam int NUM_OPS = 2;

  hitStrobe_t [NUM_OPS-1:0]         strobe;
  logic [NUM_OPS-1:0][1:0]          sel;
  logic [NUM_OPS-1:0][REG_BITS-1:0] srcReg;
  logic [NUM_OPS-1:0]               srcUsed;

  assign srcReg  = {exRt, exRs};
  assign srcUsed = {useRt, useRs};

  fwd_match_ctrl #(.REG_BITS(REG_BITS), .NUM_OPS(NUM_OPS)) u_ctrl (
    .srcReg   (srcReg),
    .srcUsed  (srcUsed),
    .exMemDst (exMemDst),
    .exMemWe  (exMemWe),
    .memWbDst (memWbDst),
    .memWbWe  (memWbWe),
    .strobe   (strobe)
  );

  fwd_sel_path #(.NUM_OPS(NUM_OPS)) u_path (
    .strobe (strobe),
    .sel    (sel)
  );

  assign selA = sel[0];
  assign selB = sel[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_BITS = 5
) (
  input logic [REG_BITS-1:0] exRs,
  input logic [REG_BITS-1:0] exRt,
  input logic                useRs,
  input logic                useRt,
  input logic [REG_BITS-1:0] exMemDst,
  input logic                exMemWe,
  input logic [REG_BITS-1:0] memWbDst,
  input logic                memWbWe,
  input logic [1:0]          selA,
  input logic [1:0]          selB
);
  always_comb begin
    // R1
    unused_a_chk: assert (useRs || selA == 2'b00);
    // R8
    unused_b_chk: assert (useRt || selB == 2'b00);
    // R9
    legal_code_chk: assert (selA != 2'b11 && selB != 2'b11);
    // R5
    zero_dst_chk: assert (!(exMemDst == '0 && memWbDst == '0) ||
                          (selA == 2'b00 && selB == 2'b00));
    // R6
    we_low_chk: assert (exMemWe || memWbWe || (selA == 2'b00 && selB == 2'b00));
    // R4
    newest_wins_chk: assert (!(useRs && exMemWe && memWbWe && exRs != '0 &&
                               exMemDst == exRs && memWbDst == exRs) || selA == 2'b10);
  end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_BITS(REG_BITS)) u_chk (
  .exRs(exRs), .exRt(exRt), .useRs(useRs), .useRt(useRt),
  .exMemDst(exMemDst), .exMemWe(exMemWe), .memWbDst(memWbDst), .memWbWe(memWbWe),
  .selA(selA), .selB(selB)
);

// File: tb/fwd_unit_test.sv
`timescale 1ns/1ps
module fwd_unit_test;
  localparam int RB = 2;
  localparam int NR = 1 << RB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [RB-1:0] exRs, exRt, exMemDst, memWbDst;
  logic useRs, useRt, exMemWe, memWbWe;
  logic [1:0] selA, selB;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  fwd_unit #(.REG_BITS(RB)) uut (
    .exRs(exRs), .exRt(exRt), .useRs(useRs), .useRt(useRt),
    .exMemDst(exMemDst), .exMemWe(exMemWe), .memWbDst(memWbDst), .memWbWe(memWbWe),
    .selA(selA), .selB(selB)
  );

  function automatic logic [1:0] expSel(input logic used, input int src,
                                        input int eD, input logic eW,
                                        input int wD, input logic wW);
    if (used && eW && eD != 0 && eD == src) return 2'b10;
    if (used && wW && wD != 0 && wD == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tagFor(input bit opB, input logic used, input int src,
                                   input int eD, input logic eW,
                                   input int wD, input logic wW);
    bit eM = eW && eD != 0 && eD == src;
    bit wM = wW && wD != 0 && wD == src;
    if (!used) return opB ? "R8" : "R1";
    if (eM && wM) return "R4";
    if (eM) return "R2";
    if (wM) return "R3";
    if (src == 0 && ((eW && eD == 0) || (wW && wD == 0))) return "R5";
    if ((!eW && eD == src) || (!wW && wD == src)) return "R6";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (rs=%0d rt=%0d uR=%b uT=%b ex=%0d/%b wb=%0d/%b)",
               tag, act, exp, exRs, exRt, useRs, useRt, exMemDst, exMemWe, memWbDst, memWbWe);
    end
  endtask

  initial begin
    #20000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    exRs = '0; exRt = '0; exMemDst = '0; memWbDst = '0;
    useRs = 0; useRt = 0; exMemWe = 0; memWbWe = 0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1", selA, 2'b00);
    check("R8", selB, 2'b00);

    // R7 directed: A from EX/MEM, B from MEM/WB, then swapped
    @(negedge clk);
    exRs = 1; exRt = 2; useRs = 1; useRt = 1;
    exMemDst = 1; exMemWe = 1; memWbDst = 2; memWbWe = 1;
    #1; check("R7", selA, 2'b10); check("R7", selB, 2'b01);
    @(negedge clk);
    exMemDst = 2; memWbDst = 1;
    #1; check("R7", selA, 2'b01); check("R7", selB, 2'b10);

    for (int fl = 0; fl < 16; fl++) begin
      for (int a = 0; a < NR; a++) begin
        for (int b = 0; b < NR; b++) begin
          for (int e = 0; e < NR; e++) begin
            for (int w = 0; w < NR; w++) begin
              @(negedge clk);
              useRs = fl[0]; useRt = fl[1]; exMemWe = fl[2]; memWbWe = fl[3];
              exRs = RB'(a); exRt = RB'(b); exMemDst = RB'(e); memWbDst = RB'(w);
              #1;
              check(tagFor(0, fl[0], a, e, fl[2], w, fl[3]), selA,
                    expSel(fl[0], a, e, fl[2], w, fl[3]));
              check(tagFor(1, fl[1], b, e, fl[2], w, fl[3]), selB,
                    expSel(fl[1], b, e, fl[2], w, fl[3]));
              // R9
              check("R9", {selA == 2'b11, selB == 2'b11}, 2'b00);
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule